// File: doc/BRIEF.md
# Second-Chance Replacement Victim Selector

This block chooses which resident physical frame to give up when memory is needed. It keeps the resident frames in a circular queue, oldest at the head, and holds one reference bit for each frame. A frame joins the tail when it is loaded. Any access to a frame sets that frame's bit. A single strobe clears every bit at once, so the bits can be aged.

When a victim is requested, the block looks at one head entry per clock. If the head's bit is set, the bit is cleared and the entry moves to the tail. If the bit is clear, that frame is the victim and leaves the queue. The selected frame index is reported with a one-cycle valid pulse. A request on an empty queue reports an error instead of a victim. An enqueue is refused when the queue is full or a scan is running.

Top module: `scq_victim_sel`

## Requirements
- R1: During reset and in the first cycle after reset, `victim_valid`, `empty_err`, `enq_reject` and `busy` are 0 and the queue holds no frames.
- R2: `ref_valid` sets the reference bit of frame `ref_idx` at the next edge. `clr_refs` clears every bit. When both occur in the same cycle, the referenced frame's bit ends up set. An accepted enqueue clears the bit of the frame it loads.
- R3: If every reference bit is clear, victims leave in the order their frames were enqueued.
- R4: During a scan, a head entry whose bit is set is not evicted. Its bit is cleared and it moves to the tail. The victim is the first entry in queue order whose bit is clear.
- R5: If no reference arrives during a scan, the victim is reported at most NUM_FRAMES+1 clock edges after the edge that accepted the request. With every bit of a full queue set, it takes exactly NUM_FRAMES+1 edges and the victim is the original head.
- R6: If a reference hits the current head in a scan cycle, that head is not evicted in that cycle. It moves to the tail and its bit stays set.
- R7: A victim request accepted while the queue is empty (and no enqueue is accepted in the same cycle) pulses `empty_err` for one cycle after the edge. No victim is produced and `busy` stays 0.
- R8: An enqueue while the queue already holds NUM_FRAMES entries pulses `enq_reject` and leaves the queue unchanged.
- R9: An enqueue while `busy` is 1 is rejected with `enq_reject`. A victim request while `busy` is 1 is ignored.
- R10: Each accepted request on a non-empty queue yields exactly one `victim_valid` pulse. `busy` falls on the same edge that raises `victim_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A frame was accessed this cycle |
| ref_idx | input | IDX_W | Index of the accessed frame |
| clr_refs | input | 1 | Clear all reference bits |
| enq_valid | input | 1 | Load a frame into the queue tail |
| enq_idx | input | IDX_W | Index of the frame being loaded |
| victim_req | input | 1 | Ask for a replacement victim |
| victim_valid | output | 1 | One-cycle pulse: `victim_idx` holds the chosen frame |
| victim_idx | output | IDX_W | Chosen victim frame |
| empty_err | output | 1 | One-cycle pulse: request made on an empty queue |
| enq_reject | output | 1 | One-cycle pulse: enqueue refused (full or busy) |
| busy | output | 1 | A scan is in progress |

## Verification
The bench builds the block with NUM_FRAMES = 4, so IDX_W is 2. With so few frames, the random stream fills the queue, hits the full-queue rejection and drains to empty many times. It also produces full wrap-around scans in which every bit is set and the scan takes five edges. Each scan's victim and cycle count are compared against a queue model kept in the bench. Directed steps place a head reference in the first scan cycle and an enqueue in the middle of a scan, and they also cover a reference and a global clear arriving in the same cycle.

// File: rtl/scq_pkg.sv
// Package: shared types for the second-chance victim selector.
// Assumes nothing beyond IEEE 1800-2017.
package scq_pkg;
    typedef enum logic {
        SCQ_IDLE = 1'b0,
        SCQ_SCAN = 1'b1
    } scq_state_e;
endpackage

// File: rtl/scq_ring.sv
// Module: circular queue of frame indices.
// Function: push appends at the tail, pop drops the head, recycle moves the head to the tail.
// Assumes: the owner never pushes while full, never pops while empty, and never pushes
// in the same cycle as a pop or recycle.
module scq_ring #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    input  logic             recycle,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [IDX_W-1:0] slot_q [DEPTH];
    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Slot storage: write the tail entry on a push or on a recycle.
    always_ff @(posedge clk) begin
        if (push || recycle)
            slot_q[tail_q] <= recycle ? slot_q[head_q] : push_idx;
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push || recycle) tail_q <= bump(tail_q);
            if (pop || recycle)  head_q <= bump(head_q);
            unique case ({push, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Status outputs.
    always_comb begin
        head_idx = slot_q[head_q];
        count    = count_q;
        full     = (count_q == CNT_W'(DEPTH));
        empty    = (count_q == '0);
    end
endmodule

// File: rtl/scq_refbits.sv
// Module: one reference bit per frame.
// Function: a set request beats both a global clear and a single-bit drop in the same cycle.
// Assumes: index inputs are below N.
module scq_refbits #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_v,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_all,
    input  logic             drop_v,
    input  logic [IDX_W-1:0] drop_idx,
    output logic [N-1:0]     bits
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // Per-frame bit update, with set taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[g] <= 1'b0;
            else if (set_v && (set_idx == IDX_W'(g)))
                bits[g] <= 1'b1;
            else if (clr_all || (drop_v && (drop_idx == IDX_W'(g))))
                bits[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/scq_scan_ctrl.sv
// Module: scan controller.
// Function: accepts requests and enqueues, walks the head one entry per clock while scanning,
// and registers the victim and the error pulses.
// Assumes: head_hit is valid whenever the queue is non-empty.
module scq_scan_ctrl
    import scq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             victim_req,
    input  logic             enq_valid,
    input  logic             q_full,
    input  logic             q_empty,
    input  logic             head_hit,
    input  logic [IDX_W-1:0] head_idx,
    output logic             enq_ok,
    output logic             recycle,
    output logic             pop,
    output logic             busy,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             empty_err,
    output logic             enq_reject
);
    scq_state_e state_q, state_d;
    logic       idle, start;

    // Decode the actions for this cycle.
    always_comb begin
        idle    = (state_q == SCQ_IDLE);
        enq_ok  = enq_valid && idle && !q_full;
        start   = victim_req && idle && (!q_empty || enq_ok);
        recycle = !idle && head_hit;
        pop     = !idle && !head_hit;
        busy    = !idle;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (idle && start)  state_d = SCQ_SCAN;
        else if (!idle && pop) state_d = SCQ_IDLE;
    end

    // State and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SCQ_IDLE;
            victim_valid <= 1'b0;
            victim_idx   <= '0;
            empty_err    <= 1'b0;
            enq_reject   <= 1'b0;
        end else begin
            state_q      <= state_d;
            victim_valid <= pop;
            if (pop) victim_idx <= head_idx;
            empty_err    <= victim_req && idle && q_empty && !enq_ok;
            enq_reject   <= enq_valid && !enq_ok;
        end
    end
endmodule

// File: rtl/scq_victim_sel.sv
// Module: second-chance victim selector (top).
// Function: joins the frame queue, the reference bits and the scan controller.
// Assumes: frame indices driven in are below NUM_FRAMES.
module scq_victim_sel #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_W = $clog2(NUM_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             clr_refs,
    input  logic             enq_valid,
    input  logic [IDX_W-1:0] enq_idx,
    input  logic             victim_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             empty_err,
    output logic             enq_reject,
    output logic             busy
);
    logic                  enq_ok, recycle, pop, head_hit;
    logic                  q_full, q_empty;
    logic [IDX_W-1:0]      head_idx;
    logic [CNT_W-1:0]      q_count;
    logic [NUM_FRAMES-1:0] ref_bits;
    logic                  drop_v;
    logic [IDX_W-1:0]      drop_idx;

    // A head counts as referenced if its bit is set or it is being accessed now.
    always_comb begin
        head_hit = ref_bits[head_idx] || (ref_valid && (ref_idx == head_idx));
        drop_v   = enq_ok || recycle;
        drop_idx = enq_ok ? enq_idx : head_idx;
    end

    scq_ring #(.DEPTH(NUM_FRAMES), .IDX_W(IDX_W), .CNT_W(CNT_W)) ring_i (
        .clk(clk), .rst_n(rst_n),
        .push(enq_ok), .push_idx(enq_idx),
        .pop(pop), .recycle(recycle),
        .head_idx(head_idx), .count(q_count),
        .full(q_full), .empty(q_empty)
    );

    scq_refbits #(.N(NUM_FRAMES), .IDX_W(IDX_W)) bits_i (
        .clk(clk), .rst_n(rst_n),
        .set_v(ref_valid), .set_idx(ref_idx),
        .clr_all(clr_refs),
        .drop_v(drop_v), .drop_idx(drop_idx),
        .bits(ref_bits)
    );

    scq_scan_ctrl #(.IDX_W(IDX_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .victim_req(victim_req), .enq_valid(enq_valid),
        .q_full(q_full), .q_empty(q_empty),
        .head_hit(head_hit), .head_idx(head_idx),
        .enq_ok(enq_ok), .recycle(recycle), .pop(pop), .busy(busy),
        .victim_valid(victim_valid), .victim_idx(victim_idx),
        .empty_err(empty_err), .enq_reject(enq_reject)
    );
endmodule

// File: rtl/scq_victim_sel_chk.sv
// Module: property checker for scq_victim_sel, bound to every instance.
// Assumes: it sees the top ports plus the queue count, the head entry and the reference bits.
module scq_victim_sel_chk #(
    parameter int NUM_FRAMES = 8,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_W = $clog2(NUM_FRAMES + 1),
    localparam int SC_W  = $clog2(NUM_FRAMES + 3)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ref_valid,
    input logic [IDX_W-1:0]      ref_idx,
    input logic                  enq_valid,
    input logic                  victim_valid,
    input logic                  empty_err,
    input logic                  enq_reject,
    input logic                  busy,
    input logic [CNT_W-1:0]      q_count,
    input logic [IDX_W-1:0]      head_idx,
    input logic [NUM_FRAMES-1:0] ref_bits
);
    logic [SC_W-1:0] scan_cnt;

    // Scan length since the later of the scan start and the last reference.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) scan_cnt <= '0;
        else if (ref_valid)  scan_cnt <= '0;
        else                 scan_cnt <= scan_cnt + SC_W'(1);
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(NUM_FRAMES));
    a_r2_ref_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> ref_bits[$past(ref_idx)]);
    a_r5_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (scan_cnt <= SC_W'(NUM_FRAMES)));
    a_r6_head_ref_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ref_valid && (ref_idx == head_idx)) |=> !victim_valid);
    a_r7_err_no_victim: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err |-> (!busy && !victim_valid));
    a_r8_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !busy && (q_count == CNT_W'(NUM_FRAMES))) |=> enq_reject);
    a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && busy) |=> enq_reject);
    a_r10_busy_ends_with_victim: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> victim_valid);
    a_r10_victim_from_scan: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> ($past(busy) && !busy));
endmodule

bind scq_victim_sel scq_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_idx(ref_idx), .enq_valid(enq_valid),
    .victim_valid(victim_valid), .empty_err(empty_err),
    .enq_reject(enq_reject), .busy(busy),
    .q_count(q_count), .head_idx(head_idx), .ref_bits(ref_bits)
);

// File: tb/scq_victim_sel_tb_top.sv
`timescale 1ns/1ps
module scq_victim_sel_tb_top;
    localparam int NF = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0, clr_refs = 1'b0, enq_valid = 1'b0, victim_req = 1'b0;
    logic [IW-1:0] ref_idx = '0, enq_idx = '0;
    logic          victim_valid, empty_err, enq_reject, busy;
    logic [IW-1:0] victim_idx;

    int n_chk = 0;
    int n_fail = 0;
    int m_q[$];
    bit m_ref[NF];
    int m_scans;

    always #2 clk = ~clk;

    scq_victim_sel #(.NUM_FRAMES(NF)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_idx(ref_idx), .clr_refs(clr_refs),
        .enq_valid(enq_valid), .enq_idx(enq_idx), .victim_req(victim_req),
        .victim_valid(victim_valid), .victim_idx(victim_idx),
        .empty_err(empty_err), .enq_reject(enq_reject), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Model of a second-chance pick; m_scans receives the number of scan cycles.
    function automatic int pick();
        int h;
        m_scans = 0;
        for (int i = 0; i < 2 * NF + 2; i++) begin
            h = m_q.pop_front();
            m_scans++;
            if (m_ref[h]) begin
                m_ref[h] = 1'b0;
                m_q.push_back(h);
            end else begin
                return h;
            end
        end
        return -1;
    endfunction

    task automatic do_enq(input int f);
        int exp_rej;
        exp_rej = (m_q.size() == NF) ? 1 : 0;
        enq_valid = 1'b1; enq_idx = IW'(f);
        @(negedge clk);
        enq_valid = 1'b0;
        chk("R8 enqueue reject", int'(enq_reject), exp_rej);
        if (exp_rej == 0) begin
            m_q.push_back(f);
            m_ref[f] = 1'b0;
        end
    endtask

    task automatic do_ref(input int f, input bit with_clr);
        ref_valid = 1'b1; ref_idx = IW'(f); clr_refs = with_clr;
        @(negedge clk);
        ref_valid = 1'b0; clr_refs = 1'b0;
        if (with_clr) for (int i = 0; i < NF; i++) m_ref[i] = 1'b0;
        m_ref[f] = 1'b1;
    endtask

    task automatic do_clr();
        clr_refs = 1'b1;
        @(negedge clk);
        clr_refs = 1'b0;
        for (int i = 0; i < NF; i++) m_ref[i] = 1'b0;
    endtask

    task automatic do_req();
        int exp_v, n;
        if (m_q.size() == 0) begin
            victim_req = 1'b1;
            @(negedge clk);
            victim_req = 1'b0;
            chk("R7 empty_err", int'(empty_err), 1);
            chk("R7 no victim", int'(victim_valid | busy), 0);
        end else begin
            exp_v = pick();
            victim_req = 1'b1;
            @(negedge clk);
            victim_req = 1'b0;
            n = 0;
            while (!victim_valid && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk("R3 R4 victim index", int'(victim_idx), exp_v);
            chk("R5 scan cycles", n, m_scans);
            chk("R10 busy low with victim", int'(busy), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 victim_valid", int'(victim_valid), 0);
        chk("R1 empty_err", int'(empty_err), 0);
        chk("R1 enq_reject", int'(enq_reject), 0);
        chk("R1 busy", int'(busy), 0);
        do_req();                               // R1 R7: queue starts empty

        // R3: FIFO order with clear bits; R8: fifth enqueue refused
        for (int i = 0; i < NF; i++) do_enq(NF - 1 - i);
        do_enq(0);
        for (int i = 0; i < NF; i++) do_req();
        do_req();

        // R2: reference plus clear in the same cycle leaves the bit set
        do_enq(1); do_enq(2);
        do_ref(2, 1'b0);
        do_ref(1, 1'b1);
        do_req();                               // expect 2, after one recycle
        do_req();

        // R6: reference to the head during its scan cycle
        do_enq(0); do_enq(1);
        victim_req = 1'b1;
        @(negedge clk);
        victim_req = 1'b0; ref_valid = 1'b1; ref_idx = 2'd0;
        @(negedge clk);
        ref_valid = 1'b0;
        chk("R6 head not evicted", int'(victim_valid), 0);
        @(negedge clk);
        chk("R6 next victim valid", int'(victim_valid), 1);
        chk("R6 next victim index", int'(victim_idx), 1);
        void'(m_q.pop_front()); void'(m_q.pop_front());
        m_q.push_back(0);
        m_ref[0] = 1'b1; m_ref[1] = 1'b0;
        do_req();                               // R6: bit kept, so two scan cycles

        // R5 R9: full wrap scan, enqueue and request during busy
        for (int i = 0; i < NF; i++) do_enq(i);
        for (int i = 0; i < NF; i++) do_ref(i, 1'b0);
        void'(pick());
        victim_req = 1'b1;
        @(negedge clk);
        enq_valid = 1'b1; enq_idx = 2'd3;
        @(negedge clk);
        enq_valid = 1'b0; victim_req = 1'b0;
        chk("R9 enqueue while busy", int'(enq_reject), 1);
        n = 1;
        while (!victim_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R5 full wrap cycles", n, NF + 1);
        chk("R5 wrap victim", int'(victim_idx), 0);
        @(negedge clk);
        chk("R9 R10 request while busy ignored", int'(victim_valid | busy), 0);

        // Random mix checked against the model
        for (int it = 0; it < 500; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: do_enq($urandom_range(0, NF - 1));
                3, 4:    do_ref($urandom_range(0, NF - 1), 1'b0);
                5:       do_ref($urandom_range(0, NF - 1), 1'b1);
                6:       do_clr();
                default: do_req();
            endcase
        end

        summary();
        $finish;
    end
endmodule